// File: doc/BRIEF.md
# Multi-Lane Signal Detect with Squelch

This block watches a group of receive lanes, each of which delivers an unsigned digital received-power code (0.25 dB per LSB). Every lane is qualified on its own. It needs a rising threshold to turn on and a lower falling threshold to turn off, which gives hysteresis. It also has a persistence filter: a lane changes state only after the new comparison has held for a programmable number of consecutive clock cycles. A single global detect flag is high only while every lane is qualified.

The same flag gates the lane data. While the flag is high, each lane's data word passes through one register stage. While it is low, every data output is held at the idle value, all zeros. The thresholds and the persistence count are static inputs driven from configuration registers. A typical setting puts the turn-on code 3 LSB (0.75 dB) above the turn-off code. The persistence count is chosen so that detect settles well inside a 50 µs response budget.

Top module: `lanes_sigdet`

## Requirements
- R1: After reset, every lane is unqualified, `detect_o` is 0 and `data_o` is all zeros.
- R2: An unqualified lane becomes qualified when `pwr_i` is greater than or equal to `thr_on_i` on `hold_i` consecutive clock edges. `detect_o` rises on the next edge after the last lane qualifies, which is `hold_i`+1 edges after the stimulus.
- R3: A power code in the band between the thresholds (at least `thr_off_i` and below `thr_on_i`) leaves a lane's state unchanged, whether the lane is qualified or not.
- R4: A qualified lane becomes unqualified when `pwr_i` is below `thr_off_i` on `hold_i` consecutive edges. `detect_o` falls `hold_i`+1 edges after the stimulus.
- R5: If the condition is broken for one or more edges before it has held for `hold_i` edges, the count restarts, so a shorter excursion does not change the lane state.
- R6: `detect_o` is the AND of all lanes: a single unqualified lane keeps it low.
- R7: While `detect_o` is 1, `data_o` equals the `data_i` value that was sampled at the same edge, which is one register delay.
- R8: While `detect_o` is 0, every bit of `data_o` is 0, whatever `data_i` carries.
- R9: A `hold_i` of 0 acts as 1, so a lane changes state at the first edge that sees the condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_on_i | input | PWR_W | Turn-on power code, common to all lanes |
| thr_off_i | input | PWR_W | Turn-off power code, common to all lanes |
| hold_i | input | CNT_W | Persistence count in cycles (0 acts as 1) |
| pwr_i | input | LANES*PWR_W | Per-lane received-power codes; lane k is at bits [k*PWR_W +: PWR_W] |
| data_i | input | LANES*DATA_W | Per-lane receive data; lane k is at bits [k*DATA_W +: DATA_W] |
| detect_o | output | 1 | Global signal detect, registered |
| data_o | output | LANES*DATA_W | Gated receive data, registered, zero while squelched |

## Verification
A lane's state register changes on the `hold_i`-th edge that sees its condition. The detect flag and the gated data are registered one edge after that, so a power step shows at `detect_o` after `hold_i`+1 edges. Data shows at `data_o` one edge after it is driven. The bench drives inputs and samples outputs 1 ns after each rising edge. For every power step it checks `detect_o` on the edge just before the due edge (expecting the old value) and again on the due edge (expecting the new one), which pins the latency exactly. The data checks compare `data_o` with the word driven before the most recent edge, and expect zero on any edge where detect is low.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;

  typedef enum logic {
    LANE_DOWN = 1'b0,
    LANE_UP   = 1'b1
  } lane_st_e;

  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_PWR_W  = 8;
  localparam int unsigned DEF_DATA_W = 10;
  localparam int unsigned DEF_CNT_W  = 16;

endpackage

// File: rtl/sigdet_lane_qual.sv
module sigdet_lane_qual
  import sigdet_pkg::*;
#(
  parameter int unsigned PWR_W = DEF_PWR_W,
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic [PWR_W-1:0] thr_on_i,
  input  logic [PWR_W-1:0] thr_off_i,
  input  logic [CNT_W-1:0] hold_i,
  output lane_st_e         state_o
);

  localparam int unsigned EXT_W = CNT_W + 1;

  lane_st_e         state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hold_eff;
  logic             flip_cond;
  logic [EXT_W-1:0] cnt_next;

  assign hold_eff  = (hold_i == '0) ? CNT_W'(1) : hold_i;
  assign flip_cond = (state_q == LANE_UP) ? (pwr_i < thr_off_i)
                                          : (pwr_i >= thr_on_i);
  assign cnt_next  = {1'b0, cnt_q} + EXT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LANE_DOWN;
      cnt_q   <= '0;
    end else if (!flip_cond) begin
      cnt_q   <= '0;
    end else if (cnt_next >= {1'b0, hold_eff}) begin
      state_q <= (state_q == LANE_UP) ? LANE_DOWN : LANE_UP;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_next[CNT_W-1:0];
    end
  end

  assign state_o = state_q;

  // R2: a lane comes up only on an edge where power met the turn-on code
  p_up_needs_on_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == LANE_UP && $past(state_q) == LANE_DOWN) |-> $past(pwr_i >= thr_on_i));

  // R4: a lane goes down only on an edge where power was below the turn-off code
  p_down_needs_off_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == LANE_DOWN && $past(state_q) == LANE_UP) |-> $past(pwr_i < thr_off_i));

  // R3: an up lane at or above turn-off stays up
  p_up_band_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == LANE_UP && pwr_i >= thr_off_i) |=> state_q == LANE_UP);

  // R3: a down lane below turn-on stays down
  p_down_band_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == LANE_DOWN && pwr_i < thr_on_i) |=> state_q == LANE_DOWN);

endmodule

// File: rtl/sigdet_squelch.sv
module sigdet_squelch
  import sigdet_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    all_up_i,
  input  logic [LANES*DATA_W-1:0] data_i,
  output logic                    detect_o,
  output logic [LANES*DATA_W-1:0] data_o
);

  logic                    det_q;
  logic [LANES*DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) det_q <= 1'b0;
    else     det_q <= all_up_i;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst || !all_up_i) data_q[k*DATA_W +: DATA_W] <= '0;
      else                  data_q[k*DATA_W +: DATA_W] <= data_i[k*DATA_W +: DATA_W];
    end
  end

  assign detect_o = det_q;
  assign data_o   = data_q;

  // R8: squelched outputs carry the idle level
  p_idle_when_low_r8: assert property (@(posedge clk) disable iff (rst)
    !det_q |-> data_q == '0);

  // R7: open outputs carry the previous cycle's input word
  p_pass_delay_r7: assert property (@(posedge clk) disable iff (rst)
    det_q |-> data_q == $past(data_i));

endmodule

// File: rtl/lanes_sigdet.sv
module lanes_sigdet
  import sigdet_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned PWR_W  = DEF_PWR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CNT_W  = DEF_CNT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PWR_W-1:0]        thr_on_i,
  input  logic [PWR_W-1:0]        thr_off_i,
  input  logic [CNT_W-1:0]        hold_i,
  input  logic [LANES*PWR_W-1:0]  pwr_i,
  input  logic [LANES*DATA_W-1:0] data_i,
  output logic                    detect_o,
  output logic [LANES*DATA_W-1:0] data_o
);

  logic [LANES-1:0] lane_up;
  logic             all_up;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_st_e st;
    sigdet_lane_qual #(
      .PWR_W (PWR_W),
      .CNT_W (CNT_W)
    ) u_qual (
      .clk       (clk),
      .rst       (rst),
      .pwr_i     (pwr_i[k*PWR_W +: PWR_W]),
      .thr_on_i  (thr_on_i),
      .thr_off_i (thr_off_i),
      .hold_i    (hold_i),
      .state_o   (st)
    );
    assign lane_up[k] = (st == LANE_UP);
  end

  assign all_up = &lane_up;

  sigdet_squelch #(
    .LANES  (LANES),
    .DATA_W (DATA_W)
  ) u_sq (
    .clk      (clk),
    .rst      (rst),
    .all_up_i (all_up),
    .data_i   (data_i),
    .detect_o (detect_o),
    .data_o   (data_o)
  );

  // R6: detect high only if every lane was up at the previous edge
  p_detect_and_r6: assert property (@(posedge clk) disable iff (rst)
    detect_o |-> $past(&lane_up));

  // R6: a down lane forces detect low at the next edge
  p_any_down_r6: assert property (@(posedge clk) disable iff (rst)
    (lane_up != '1) |=> !detect_o);

endmodule

// File: tb/lanes_sigdet_bench.sv
`timescale 1ns/1ps
module lanes_sigdet_bench;

  localparam int LANES  = 4;
  localparam int PWR_W  = 8;
  localparam int DATA_W = 10;
  localparam int CNT_W  = 16;
  localparam int HOLD   = 4;
  localparam logic [PWR_W-1:0] T_ON  = 8'd40;
  localparam logic [PWR_W-1:0] T_OFF = 8'd37;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [PWR_W-1:0]        thr_on  = T_ON;
  logic [PWR_W-1:0]        thr_off = T_OFF;
  logic [CNT_W-1:0]        hold    = CNT_W'(HOLD);
  logic [LANES*PWR_W-1:0]  pwr     = '0;
  logic [LANES*DATA_W-1:0] din     = '0;
  logic                    detect;
  logic [LANES*DATA_W-1:0] dout;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lanes_sigdet #(.LANES(LANES), .PWR_W(PWR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_lanes_sigdet (
    .clk(clk), .rst(rst), .thr_on_i(thr_on), .thr_off_i(thr_off), .hold_i(hold),
    .pwr_i(pwr), .data_i(din), .detect_o(detect), .data_o(dout)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic set_lane(input int k, input logic [PWR_W-1:0] v);
    pwr[k*PWR_W +: PWR_W] = v;
  endtask

  task automatic set_all(input logic [PWR_W-1:0] v);
    for (int k = 0; k < LANES; k++) set_lane(k, v);
  endtask

  task automatic t_reset;
    set_all(8'd60);
    din = '1;
    rst = 1'b1;
    step(3);
    check(detect == 1'b0, "R1 detect after reset", detect, 0);
    check(dout == '0, "R1 data after reset", dout, 0);
    rst = 1'b0;
    set_all(8'd0);
    din = '0;
    step(1);
  endtask

  task automatic t_rise;
    set_all(8'd50);
    step(HOLD);
    check(detect == 1'b0, "R2 detect one edge before due", detect, 0);
    step(1);
    check(detect == 1'b1, "R2 detect on due edge", detect, 1);
  endtask

  task automatic t_data_pass;
    for (int i = 0; i < 5; i++) begin
      logic [LANES*DATA_W-1:0] w;
      w = {LANES{10'(37 * i + 5)}} ^ 40'h5_A5A5_3C3C;
      din = w;
      step(1);
      check(detect == 1'b1, "R7 detect held", detect, 1);
      check(dout == w, "R7 data passes one-cycle delay", dout, w);
    end
  endtask

  task automatic t_band;
    set_lane(0, 8'd38);
    set_lane(3, T_OFF);
    step(20);
    check(detect == 1'b1, "R3 up lanes in band stay up", detect, 1);
    set_lane(0, 8'd50);
    set_lane(3, 8'd50);
    step(1);
  endtask

  task automatic t_fall;
    set_lane(2, 8'd30);
    step(HOLD);
    check(detect == 1'b1, "R4 detect one edge before fall", detect, 1);
    step(1);
    check(detect == 1'b0, "R4 R6 detect falls on due edge", detect, 0);
  endtask

  task automatic t_squelch;
    for (int i = 0; i < 3; i++) begin
      din = {LANES{10'h3FF}} ^ 40'(i);
      step(1);
      check(dout == '0, "R8 data zero while squelched", dout, 0);
    end
  endtask

  task automatic t_down_band;
    set_lane(2, 8'd39);
    step(20);
    check(detect == 1'b0, "R3 R6 down lane in band stays down", detect, 0);
  endtask

  task automatic t_glitch;
    set_lane(2, 8'd50);
    step(HOLD - 1);
    set_lane(2, 8'd30);
    step(1);
    set_lane(2, 8'd50);
    step(HOLD - 1);
    check(detect == 1'b0, "R5 interrupted count restarts", detect, 0);
    step(1);
    check(detect == 1'b0, "R5 lane just qualified, detect not yet", detect, 0);
    step(1);
    check(detect == 1'b1, "R5 detect after full hold", detect, 1);
  endtask

  task automatic t_hold_zero;
    hold = '0;
    set_lane(1, 8'd10);
    step(1);
    check(detect == 1'b1, "R9 hold zero, before due", detect, 1);
    step(1);
    check(detect == 1'b0, "R9 hold zero acts as one", detect, 0);
    set_lane(1, 8'd50);
    step(2);
    check(detect == 1'b1, "R9 hold zero rise", detect, 1);
    hold = CNT_W'(HOLD);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_rise();
        t_data_pass();
        t_band();
        t_fall();
        t_squelch();
        t_down_band();
        t_glitch();
        t_hold_zero();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule